// File: doc/BRIEF.md
# Temperature Sensor Serial Register Port

This block is the serial slave port of a digital temperature sensor. An external host drives a four-wire serial bus (serial clock, active-low select, data in, data out), and the block turns each select window into one access to an eight-entry register file of mixed 8-bit and 16-bit registers. The serial pins are oversampled by the faster system clock, and all bus events are recovered from synchronised edges.

Every transaction opens with an 8-bit command. Bit 7 must be zero and bit 6 selects a read when set. Bits 5:3 carry the register address, bit 2 flags continuous reading, and bits 1:0 are zero. The writable limit and configuration registers are driven out in parallel to the alarm and conversion logic. The status byte and the temperature word are taken in from that logic. A read strobe and a write strobe, each with its address, tell the neighbouring logic which access finished. A streaming mode repeats the temperature word without new commands. A run of consecutive ones on the data input acts as a bus-recovery reset, and a soft-reset pulse is issued to the neighbouring logic when it fires.

Top module: `tsp_spi_regif`

## Requirements
- R1: Command bits are decoded as bit7 = 0, bit6 = 1 for read, bits5:3 = address, bit2 = stream flag, bits1:0 = 00. A command with bit7 = 1 makes the rest of that select window inert: the data output returns zeros and no register is written.
- R2: The data input is sampled on rising serial-clock edges and the data output changes on falling edges. The first data bit after the command appears on the first falling edge after the eighth rising edge, MSB first.
- R3: Addresses 0 (status), 1 (configuration), 3 (identity) and 5 (hysteresis) are 8 bits wide. Addresses 2 (temperature), 4 (critical limit), 6 (high limit) and 7 (low limit) are 16 bits wide.
- R4: Addresses 0, 2 and 3 are read-only. A write to any of them changes nothing and raises no write strobe. A write to a writable address takes the data bits that follow the command.
- R5: Each select window accesses at most one register. Clocks beyond the data field return zeros on the output and are not written. Raising the select line ends the transaction.
- R6: Command 0x54 enters a sticky streaming mode in which every group of 16 serial clocks shifts out the temperature word, also in later select windows. When 0x50 arrives as the first byte of a group, the mode ends.
- R7: In streaming mode, a group that starts while the conversion-busy input is high shifts out all zeros.
- R8: Thirty-two consecutive ones sampled on the data input restore every writable register to its default and pulse the soft-reset output. The port then expects a command byte, even within the same select window.
- R9: Defaults are configuration 0x00, hysteresis 0x05, critical limit 0x4980, high limit 0x2000 and low limit 0x0500. Identity reads 0xC0 plus a 4-bit revision parameter (default 3, so 0xC3).
- R10: The output enable is low, and the data output is 0, while the select line is high.
- R11: The read strobe pulses for one system clock, with the address, on every completed register read, including each streamed group. The write strobe pulses once per accepted write. The two never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Active-low select |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Serial data to host |
| dout_oe | output | 1 | Output enable for the data pin |
| stat_i | input | 8 | Status byte from alarm logic |
| temp_i | input | 16 | Temperature word from the converter |
| conv_busy | input | 1 | Conversion in progress |
| cfg_o | output | 8 | Configuration register |
| hyst_o | output | 8 | Hysteresis register |
| crit_o | output | 16 | Critical limit register |
| high_o | output | 16 | High limit register |
| low_o | output | 16 | Low limit register |
| rd_stb | output | 1 | Completed-read pulse |
| rd_addr | output | 3 | Address of the completed read |
| wr_stb | output | 1 | Accepted-write pulse |
| wr_addr | output | 3 | Address of the accepted write |
| soft_rst | output | 1 | Pulse after a bus-recovery reset |

## Verification
The command decoder is driven with every read width and with writes to writable and read-only addresses. This separates width handling from the write protection. Commands with the top bit set, and windows longer than the data field, show that the port stays inert outside one valid access. Streaming is tried within one window, across windows, with the busy input high, and with the exit byte, followed by a plain read that would fail if streaming were still on. The recovery run of ones is sent as one window that carries a command after it, so a reset that does not re-arm the command decoder is caught.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

   localparam int ADDR_W  = 3;
   localparam int WORD_W  = 16;
   localparam int BYTE_W  = 8;
   localparam int N_LIMIT = 3;

   typedef logic [ADDR_W-1:0] addr_t;

   localparam addr_t A_STAT = 3'd0;
   localparam addr_t A_CFG  = 3'd1;
   localparam addr_t A_TEMP = 3'd2;
   localparam addr_t A_ID   = 3'd3;
   localparam addr_t A_HYST = 3'd5;

   localparam logic [BYTE_W-1:0] CMD_STREAM_ON  = 8'h54;
   localparam logic [BYTE_W-1:0] CMD_STREAM_OFF = 8'h50;

   localparam logic [BYTE_W-1:0] CFG_DEF  = 8'h00;
   localparam logic [BYTE_W-1:0] HYST_DEF = 8'h05;
   localparam logic [BYTE_W-1:0] ID_BASE  = 8'hC0;

   typedef enum logic [1:0] {
      FS_CMD,
      FS_DATA,
      FS_STRM,
      FS_IGN
   } fstate_t;

   function automatic logic is_wide(addr_t a);
      return (a == 3'd2) || (a == 3'd4) || (a == 3'd6) || (a == 3'd7);
   endfunction

   function automatic logic is_ro(addr_t a);
      return (a == A_STAT) || (a == A_TEMP) || (a == A_ID);
   endfunction

   // limit slot g: 0 critical, 1 high, 2 low
   function automatic addr_t lim_addr(int g);
      case (g)
         0:       return 3'd4;
         1:       return 3'd6;
         default: return 3'd7;
      endcase
   endfunction

   function automatic logic [WORD_W-1:0] lim_default(int g);
      case (g)
         0:       return 16'h4980;
         1:       return 16'h2000;
         default: return 16'h0500;
      endcase
   endfunction

endpackage

// File: rtl/tsp_sync.sv
module tsp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic cs_n,
   input  logic din,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic cs_act,
   output logic cs_start,
   output logic din_s
);

   logic [STAGES-1:0] sclk_p, cs_p, din_p;
   logic              sclk_d, cs_d;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sclk_p[0] <= 1'b1;
               cs_p[0]   <= 1'b1;
               din_p[0]  <= 1'b0;
            end else begin
               sclk_p[0] <= sclk;
               cs_p[0]   <= cs_n;
               din_p[0]  <= din;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sclk_p[g] <= 1'b1;
               cs_p[g]   <= 1'b1;
               din_p[g]  <= 1'b0;
            end else begin
               sclk_p[g] <= sclk_p[g-1];
               cs_p[g]   <= cs_p[g-1];
               din_p[g]  <= din_p[g-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b1;
         cs_d   <= 1'b1;
      end else begin
         sclk_d <= sclk_p[STAGES-1];
         cs_d   <= cs_p[STAGES-1];
      end
   end

   assign sclk_rise = sclk_p[STAGES-1] & ~sclk_d;
   assign sclk_fall = ~sclk_p[STAGES-1] & sclk_d;
   assign cs_act    = ~cs_p[STAGES-1];
   assign cs_start  = ~cs_p[STAGES-1] & cs_d;
   assign din_s     = din_p[STAGES-1];

endmodule

// File: rtl/tsp_frame.sv
module tsp_frame
   import tsp_pkg::*;
#(
   parameter int ONES_RESET = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic              fall,
   input  logic              cs_act,
   input  logic              cs_start,
   input  logic              din_s,
   input  logic              conv_busy,
   input  logic [WORD_W-1:0] temp_i,
   input  logic [WORD_W-1:0] look_data,
   output addr_t             look_addr,
   output logic              dout_q,
   output logic              rd_stb,
   output addr_t             rd_addr,
   output logic              wr_stb,
   output addr_t             wr_addr,
   output logic [WORD_W-1:0] wr_data,
   output logic              soft_rst
);

   localparam int OW = $clog2(ONES_RESET);

   fstate_t           state;
   logic [4:0]        bitcnt;
   logic [WORD_W-2:0] shin;
   logic [WORD_W-1:0] shout;
   addr_t             cur_addr;
   logic              cur_rd, cur_wide, cont;
   logic [OW-1:0]     ones;

   logic [BYTE_W-1:0] nxt_byte;
   logic [WORD_W-1:0] nxt_word, stream_word;
   logic [4:0]        data_last;
   logic              srst_hit;

   assign nxt_byte    = {shin[BYTE_W-2:0], din_s};
   assign nxt_word    = {shin, din_s};
   assign look_addr   = nxt_byte[5:3];
   assign stream_word = conv_busy ? '0 : temp_i;
   assign data_last   = cur_wide ? 5'd15 : 5'd7;
   assign srst_hit    = rise && cs_act && din_s && (ones == OW'(ONES_RESET - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= FS_CMD;
         bitcnt   <= '0;
         shin     <= '0;
         shout    <= '0;
         cur_addr <= '0;
         cur_rd   <= 1'b0;
         cur_wide <= 1'b0;
         cont     <= 1'b0;
         ones     <= '0;
         dout_q   <= 1'b0;
         rd_stb   <= 1'b0;
         rd_addr  <= '0;
         wr_stb   <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
         soft_rst <= 1'b0;
      end else begin
         rd_stb   <= 1'b0;
         wr_stb   <= 1'b0;
         soft_rst <= 1'b0;
         if (srst_hit) begin
            state    <= FS_CMD;
            bitcnt   <= '0;
            cont     <= 1'b0;
            ones     <= '0;
            shout    <= '0;
            dout_q   <= 1'b0;
            soft_rst <= 1'b1;
         end else if (!cs_act) begin
            state  <= FS_CMD;
            bitcnt <= '0;
            dout_q <= 1'b0;
         end else if (cs_start) begin
            if (cont) begin
               state <= FS_STRM;
               shout <= stream_word;
            end
         end else if (rise) begin
            shin   <= nxt_word[WORD_W-2:0];
            ones   <= din_s ? ones + 1'b1 : '0;
            bitcnt <= bitcnt + 5'd1;
            case (state)
               FS_CMD: if (bitcnt == 5'd7) begin
                  bitcnt <= '0;
                  if (nxt_byte[7]) begin
                     state <= FS_IGN;
                  end else if (nxt_byte == CMD_STREAM_ON) begin
                     cont  <= 1'b1;
                     state <= FS_STRM;
                     shout <= stream_word;
                  end else begin
                     cur_addr <= nxt_byte[5:3];
                     cur_rd   <= nxt_byte[6];
                     cur_wide <= is_wide(nxt_byte[5:3]);
                     shout    <= look_data;
                     state    <= FS_DATA;
                  end
               end
               FS_DATA: if (bitcnt == data_last) begin
                  state <= FS_IGN;
                  if (cur_rd) begin
                     rd_stb  <= 1'b1;
                     rd_addr <= cur_addr;
                  end else if (!is_ro(cur_addr)) begin
                     wr_stb  <= 1'b1;
                     wr_addr <= cur_addr;
                     wr_data <= cur_wide ? nxt_word : {8'h00, nxt_byte};
                  end
               end
               FS_STRM: begin
                  if (bitcnt == 5'd7 && nxt_byte == CMD_STREAM_OFF) begin
                     cont  <= 1'b0;
                     state <= FS_IGN;
                  end else if (bitcnt == 5'd15) begin
                     bitcnt  <= '0;
                     rd_stb  <= 1'b1;
                     rd_addr <= A_TEMP;
                     shout   <= stream_word;
                  end
               end
               default: bitcnt <= bitcnt;
            endcase
         end else if (fall) begin
            if ((state == FS_DATA && cur_rd) || state == FS_STRM) begin
               dout_q <= shout[WORD_W-1];
               shout  <= {shout[WORD_W-2:0], 1'b0};
            end else begin
               dout_q <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/tsp_regbank.sv
module tsp_regbank
   import tsp_pkg::*;
#(
   parameter logic [3:0] ID_REV = 4'h3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              wr_stb,
   input  addr_t             wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  addr_t             look_addr,
   input  logic [BYTE_W-1:0] stat_i,
   input  logic [WORD_W-1:0] temp_i,
   output logic [BYTE_W-1:0] cfg_o,
   output logic [BYTE_W-1:0] hyst_o,
   output logic [WORD_W-1:0] crit_o,
   output logic [WORD_W-1:0] high_o,
   output logic [WORD_W-1:0] low_o,
   output logic [WORD_W-1:0] look_data
);

   localparam logic [BYTE_W-1:0] ID_VAL = ID_BASE | {4'h0, ID_REV};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_o  <= CFG_DEF;
         hyst_o <= HYST_DEF;
      end else if (soft_rst) begin
         cfg_o  <= CFG_DEF;
         hyst_o <= HYST_DEF;
      end else if (wr_stb) begin
         if (wr_addr == A_CFG)  cfg_o  <= wr_data[BYTE_W-1:0];
         if (wr_addr == A_HYST) hyst_o <= wr_data[BYTE_W-1:0];
      end
   end

   for (genvar g = 0; g < N_LIMIT; g++) begin : g_lim
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  q <= lim_default(g);
         else if (soft_rst)                           q <= lim_default(g);
         else if (wr_stb && wr_addr == lim_addr(g))   q <= wr_data;
      end
   end

   assign crit_o = g_lim[0].q;
   assign high_o = g_lim[1].q;
   assign low_o  = g_lim[2].q;

   // 8-bit registers are left-justified so the MSB leaves first
   always_comb begin
      case (look_addr)
         3'd0:    look_data = {stat_i, 8'h00};
         3'd1:    look_data = {cfg_o, 8'h00};
         3'd2:    look_data = temp_i;
         3'd3:    look_data = {ID_VAL, 8'h00};
         3'd4:    look_data = crit_o;
         3'd5:    look_data = {hyst_o, 8'h00};
         3'd6:    look_data = high_o;
         default: look_data = low_o;
      endcase
   end

endmodule

// File: rtl/tsp_spi_regif.sv
module tsp_spi_regif
   import tsp_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         ONES_RESET  = 32,
   parameter logic [3:0] ID_REV      = 4'h3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sclk,
   input  logic        cs_n,
   input  logic        din,
   output logic        dout,
   output logic        dout_oe,
   input  logic [7:0]  stat_i,
   input  logic [15:0] temp_i,
   input  logic        conv_busy,
   output logic [7:0]  cfg_o,
   output logic [7:0]  hyst_o,
   output logic [15:0] crit_o,
   output logic [15:0] high_o,
   output logic [15:0] low_o,
   output logic        rd_stb,
   output logic [2:0]  rd_addr,
   output logic        wr_stb,
   output logic [2:0]  wr_addr,
   output logic        soft_rst
);

   initial begin
      if (SYNC_STAGES < 2)
         $fatal(1, "SYNC_STAGES must be at least 2");
      if (ONES_RESET < 2 || ONES_RESET > 64)
         $fatal(1, "ONES_RESET out of range");
   end

   logic              s_rise, s_fall, s_act, s_start, s_din, dout_q;
   addr_t             look_addr;
   logic [WORD_W-1:0] look_data, wr_data;

   tsp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk      (sclk),
      .cs_n      (cs_n),
      .din       (din),
      .sclk_rise (s_rise),
      .sclk_fall (s_fall),
      .cs_act    (s_act),
      .cs_start  (s_start),
      .din_s     (s_din)
   );

   tsp_frame #(.ONES_RESET(ONES_RESET)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise      (s_rise),
      .fall      (s_fall),
      .cs_act    (s_act),
      .cs_start  (s_start),
      .din_s     (s_din),
      .conv_busy (conv_busy),
      .temp_i    (temp_i),
      .look_data (look_data),
      .look_addr (look_addr),
      .dout_q    (dout_q),
      .rd_stb    (rd_stb),
      .rd_addr   (rd_addr),
      .wr_stb    (wr_stb),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .soft_rst  (soft_rst)
   );

   tsp_regbank #(.ID_REV(ID_REV)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .wr_stb    (wr_stb),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .look_addr (look_addr),
      .stat_i    (stat_i),
      .temp_i    (temp_i),
      .cfg_o     (cfg_o),
      .hyst_o    (hyst_o),
      .crit_o    (crit_o),
      .high_o    (high_o),
      .low_o     (low_o),
      .look_data (look_data)
   );

   assign dout_oe = s_act & ~cs_n;
   assign dout    = dout_oe ? dout_q : 1'b0;

endmodule

// File: rtl/tsp_checker.sv
module tsp_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        cs_n,
   input logic        dout_oe,
   input logic        rd_stb,
   input logic        wr_stb,
   input logic [2:0]  wr_addr,
   input logic        soft_rst,
   input logic [7:0]  cfg_o,
   input logic [7:0]  hyst_o,
   input logic [15:0] crit_o,
   input logic [15:0] high_o,
   input logic [15:0] low_o
);

   a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_stb && wr_stb));

   a_r4_wr_writable: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (wr_addr != 3'd0 && wr_addr != 3'd2 && wr_addr != 3'd3));

   a_r4_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stb && !soft_rst) |=> $stable(cfg_o));

   a_r8_soft_defaults: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (cfg_o == 8'h00 && hyst_o == 8'h05 && crit_o == 16'h4980 &&
                    high_o == 16'h2000 && low_o == 16'h0500));

   a_r10_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
      dout_oe |-> $past(!cs_n));

endmodule

bind tsp_spi_regif tsp_checker u_chk (.*);

// File: tb/sim_tsp_spi_regif.sv
module sim_tsp_spi_regif;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b1, cs_n = 1'b1, din = 1'b0;
   logic        dout, dout_oe;
   logic [7:0]  stat_i = 8'h80;
   logic [15:0] temp_i = 16'h0C80;
   logic        conv_busy = 1'b0;
   logic [7:0]  cfg_o, hyst_o;
   logic [15:0] crit_o, high_o, low_o;
   logic        rd_stb, wr_stb, soft_rst;
   logic [2:0]  rd_addr, wr_addr;

   always #10 clk = ~clk;

   tsp_spi_regif u0 (.*);

   int total = 0, bad = 0;
   int rd_cnt = 0, wr_cnt = 0, srst_cnt = 0;
   int exp_q[$];
   int act_q[$];
   string tag_q[$];

   always @(posedge clk) begin
      if (rd_stb) rd_cnt++;
      if (wr_stb) wr_cnt++;
      if (soft_rst) srst_cnt++;
   end

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   initial forever begin
      @(posedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0)
         chk(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
   end

   task automatic spi(input logic [47:0] mosi, input int nb, output logic [47:0] miso);
      miso = '0;
      cs_n = 1'b0;
      repeat (8) @(negedge clk);
      for (int i = nb - 1; i >= 0; i--) begin
         sclk = 1'b0;
         din  = mosi[i];
         repeat (8) @(negedge clk);
         miso = {miso[46:0], dout};
         sclk = 1'b1;
         repeat (8) @(negedge clk);
      end
      din  = 1'b0;
      cs_n = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   task automatic rd(string tag, logic [7:0] cmd, bit wide, int exp);
      logic [47:0] m;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      if (wide) begin
         spi({24'h0, cmd, 16'h0}, 24, m);
         act_q.push_back(int'(m[15:0]));
      end else begin
         spi({32'h0, cmd, 8'h0}, 16, m);
         act_q.push_back(int'(m[7:0]));
      end
   endtask

   task automatic wr(logic [7:0] cmd, bit wide, logic [15:0] data);
      logic [47:0] m;
      if (wide) spi({24'h0, cmd, data}, 24, m);
      else      spi({32'h0, cmd, data[7:0]}, 16, m);
   endtask

   task automatic push(string tag, int act, int exp);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      act_q.push_back(act);
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [47:0] m;
      int base;
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R9 defaults, R10 idle output
      push("R9 cfg default", cfg_o, 8'h00);
      push("R9 hyst default", hyst_o, 8'h05);
      push("R9 crit default", crit_o, 16'h4980);
      push("R9 high default", high_o, 16'h2000);
      push("R9 low default", low_o, 16'h0500);
      push("R10 oe idle", {dout_oe, dout}, 0);

      // R2/R3 reads of each width
      rd("R9 id read", 8'h58, 0, 8'hC3);
      rd("R3 status 8-bit", 8'h40, 0, 8'h80);
      rd("R2 temp 16-bit", 8'h50, 1, 16'h0C80);
      rd("R3 crit 16-bit", 8'h60, 1, 16'h4980);
      push("R11 read strobes", rd_cnt, 4);
      push("R11 read addr", rd_addr, 4);

      // R4 writable registers
      wr(8'h08, 0, 16'h00A5);
      push("R4 cfg written", cfg_o, 8'hA5);
      wr(8'h30, 1, 16'h1F40);
      push("R4 high written", high_o, 16'h1F40);
      wr(8'h28, 0, 16'h000A);
      rd("R4 hyst readback", 8'h68, 0, 8'h0A);
      push("R11 write strobes", wr_cnt, 3);

      // R4 read-only addresses
      wr(8'h10, 1, 16'h5555);
      wr(8'h18, 0, 16'h0077);
      push("R4 no strobe on ro", wr_cnt, 3);
      rd("R4 temp unchanged", 8'h50, 1, 16'h0C80);
      rd("R4 id unchanged", 8'h58, 0, 8'hC3);

      // R1 top bit set
      wr(8'h88, 0, 16'h003C);
      push("R1 ignored write", cfg_o, 8'hA5);
      rd("R1 ignored read", 8'hC8, 0, 0);

      // R5 over-long windows
      spi({24'h0, 8'h48, 16'h0}, 24, m);
      push("R5 extra clocks zero", int'(m[15:0]), 16'hA500);
      spi({8'h0, 8'h38, 32'h1234ABCD}, 40, m);
      push("R5 single write", low_o, 16'h1234);

      // R6 streaming
      temp_i = 16'h1234;
      base = rd_cnt;
      spi({8'h54, 32'h0}, 40, m);
      push("R6 two groups", int'(m[31:0]), 32'h12341234);
      push("R11 stream strobes", rd_cnt - base, 2);
      push("R11 stream addr", rd_addr, 2);
      spi(48'h0, 16, m);
      push("R6 sticky mode", int'(m[15:0]), 16'h1234);
      conv_busy = 1'b1;
      spi(48'h0, 16, m);
      push("R7 busy zeros", int'(m[15:0]), 0);
      conv_busy = 1'b0;
      spi({32'h0, 16'h5000}, 16, m);
      push("R6 exit window", int'(m[15:0]), 16'h1200);
      rd("R6 normal after exit", 8'h48, 0, 8'hA5);

      // R8 recovery run followed by a command in the same window
      wr(8'h20, 1, 16'h0100);
      wr(8'h08, 0, 16'h003C);
      spi({32'hFFFFFFFF, 8'h48, 8'h00}, 48, m);
      push("R8 cmd after reset", int'(m[7:0]), 0);
      push("R8 soft pulse", srst_cnt, 1);
      push("R8 cfg restored", cfg_o, 8'h00);
      push("R8 crit restored", crit_o, 16'h4980);
      push("R8 low restored", low_o, 16'h0500);
      push("R8 hyst restored", hyst_o, 8'h05);
      push("R10 oe idle end", {dout_oe, dout}, 0);

      repeat (10) @(negedge clk);
      while (act_q.size() > 0) @(negedge clk);
      finish_run();
   end

endmodule